// File: doc/BRIEF.md
# Scalar Single-Precision Move Form Decoder

This block takes the encoding fields of one scalar single-precision move instruction and turns them into control for an execution datapath. Prefix and escape bytes have already been parsed upstream. The block receives:

- an encoding class: legacy, two-source vector, or masked vector;
- the opcode byte;
- a flag telling whether the mandatory repeat prefix was present;
- the ModRM mod field;
- the extra-source register specifier;
- the vector-length bit;
- the mask register index and the zeroing bit.

From these it produces:

- the operation form: register merge, load, or store;
- which encoding field supplies the destination and each source;
- the masking mode;
- the policy for the destination bits above the low 32-bit element;
- an undefined-opcode fault;
- a length warning.

The decode is combinational and ends in one output register. Both sides use a valid/ready handshake. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. The decoded result appears on the outputs at the next edge with `out_valid` set. While `out_valid` is high and `out_ready` is low, the result is held and `in_ready` stays low, so back-pressure passes straight through to the producer. When `out_ready` is high, a new request may be accepted in the same cycle that the held result leaves, so the block sustains one decode per cycle.

Top module: `ssmov_decoder`

## Requirements
- R1: A request is recognised only when `in_f3`=1, `in_enc` is 0 (legacy), 1 (two-source vector) or 2 (masked vector), and `in_opcode` is 8'h10 or 8'h11. Any other request gives `out_ud`=1, `out_form`=3, all three role outputs 0, `out_mask`=0 and `out_upper`=4.
- R2: Form codes are 0 for register merge, 1 for load, 2 for store and 3 for none. `in_mod`=2'b11 selects the register merge form. Any other mod gives load for opcode 8'h10 and store for opcode 8'h11.
- R3: A load drives destination=1 (ModRM.reg), first source=0 (unused) and second source=2 (ModRM.r/m). Role codes are 0 for none, 1 for ModRM.reg, 2 for ModRM.r/m and 3 for the extra specifier.
- R4: A store drives destination=2 (ModRM.r/m), first source=0 and second source=1 (ModRM.reg).
- R5: A legacy register form with opcode 8'h10 gives destination=1, first source=1, second source=2. With opcode 8'h11 it gives destination=2, first source=2, second source=1.
- R6: A vector register form (class 1 or 2) with opcode 8'h10 gives destination=1, first source=3, second source=2. With opcode 8'h11 it gives destination=2, first source=3, second source=1.
- R7: A store in class 1 or 2 whose `in_xspec` is not all ones faults as in R1. A legacy store ignores `in_xspec`.
- R8: `out_mask` is 0 (no mask) for classes 0 and 1, and for class 2 with `in_kidx`=0. Otherwise it is 2 (zeroing) when `in_zero`=1 and 1 (merging) when `in_zero`=0.
- R9: A class-2 store with `in_zero`=1 faults. A class-2 store with `in_zero`=0 and a nonzero `in_kidx` gives `out_mask`=1.
- R10: `out_upper` gives the policy for destination bits above the low element. The codes are: 0 keep all (legacy register), 1 clear up to bit 127 and keep the rest (legacy load), 2 copy from the first source and clear above 128 (vector register), 3 clear all (vector load), 4 not applicable (store or fault).
- R11: `out_lenwarn`=1 only for a non-faulting class-1 request with `in_len`=1. Class 2 ignores `in_len`.
- R12: `in_ready` = !`out_valid` || `out_ready`. An accepted request appears one edge later. A result is held unchanged while `out_valid`=1 and `out_ready`=0.
- R13: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_enc | input | 2 | Encoding class (0 legacy, 1 two-source, 2 masked) |
| in_opcode | input | 8 | Opcode byte after escape |
| in_f3 | input | 1 | Mandatory repeat prefix present |
| in_mod | input | 2 | ModRM mod field |
| in_xspec | input | XSPEC_W | Extra-source register specifier |
| in_len | input | 1 | Vector-length bit |
| in_kidx | input | KIDX_W | Mask register index |
| in_zero | input | 1 | Zeroing-mask bit |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_form | output | 2 | Operation form |
| out_dst | output | 2 | Destination role |
| out_src1 | output | 2 | First source role |
| out_src2 | output | 2 | Second source role |
| out_mask | output | 2 | Masking mode |
| out_upper | output | 3 | Upper-bit policy |
| out_ud | output | 1 | Undefined-opcode fault |
| out_lenwarn | output | 1 | Length warning |

## Verification
Every decoded field is due exactly one rising edge after the edge that accepts a request. The bench drives each request at a falling edge and compares the whole output set at the next falling edge, which lies half a cycle after the result register loads. For the back-pressure case, the bench holds `out_ready` low over two further falling edges and checks that the first result is unchanged. It then raises `out_ready` and expects the queued request to appear after one more edge.

// File: rtl/ssmov_pkg.sv
package ssmov_pkg;
  typedef enum logic [1:0] {ENC_LEG = 2'd0, ENC_VEC2 = 2'd1, ENC_VECM = 2'd2, ENC_RSVD = 2'd3} enc_e;
  typedef enum logic [1:0] {FORM_MERGE = 2'd0, FORM_LOAD = 2'd1, FORM_STORE = 2'd2, FORM_NONE = 2'd3} form_e;
  typedef enum logic [1:0] {ROLE_NONE = 2'd0, ROLE_REG = 2'd1, ROLE_RM = 2'd2, ROLE_XSPEC = 2'd3} role_e;
  typedef enum logic [1:0] {MASK_OFF = 2'd0, MASK_MERGE = 2'd1, MASK_ZERO = 2'd2, MASK_RSVD = 2'd3} mask_e;
  typedef enum logic [2:0] {UP_KEEP = 3'd0, UP_ZLANE = 3'd1, UP_SRC1 = 3'd2, UP_ZALL = 3'd3, UP_NA = 3'd4} upper_e;

  localparam logic [7:0] OPC_LOADSIDE  = 8'h10;
  localparam logic [7:0] OPC_STORESIDE = 8'h11;
  localparam logic [1:0] MOD_REGFORM   = 2'b11;

  typedef struct packed {
    form_e  form;
    role_e  dst;
    role_e  src1;
    role_e  src2;
    mask_e  mask;
    upper_e upper;
    logic   ud;
    logic   lwarn;
  } decode_t;
endpackage

// File: rtl/ssmov_classify.sv
module ssmov_classify
  import ssmov_pkg::*;
(
  input  enc_e       enc,
  input  logic [7:0] opcode,
  input  logic       f3,
  input  logic [1:0] mod_f,
  output logic       recognised,
  output logic       is_store,
  output form_e      form,
  output role_e      dst,
  output role_e      src1,
  output role_e      src2,
  output upper_e     upper
);
  logic opc_hit;
  logic reg_form;
  logic st_side;
  logic vec_enc;

  assign opc_hit    = (opcode == OPC_LOADSIDE) || (opcode == OPC_STORESIDE);
  assign recognised = f3 && opc_hit && (enc != ENC_RSVD);
  assign reg_form   = (mod_f == MOD_REGFORM);
  // the low opcode bit decides which ModRM field is written
  assign st_side    = opcode[0];
  assign vec_enc    = (enc == ENC_VEC2) || (enc == ENC_VECM);
  assign is_store   = recognised && !reg_form && st_side;

  always_comb begin
    form  = FORM_NONE;
    dst   = ROLE_NONE;
    src1  = ROLE_NONE;
    src2  = ROLE_NONE;
    upper = UP_NA;
    if (recognised) begin
      if (reg_form) begin
        form  = FORM_MERGE;
        dst   = st_side ? ROLE_RM : ROLE_REG;
        src2  = st_side ? ROLE_REG : ROLE_RM;
        if (vec_enc) begin
          src1  = ROLE_XSPEC;
          upper = UP_SRC1;
        end else begin
          src1  = dst;
          upper = UP_KEEP;
        end
      end else if (!st_side) begin
        form  = FORM_LOAD;
        dst   = ROLE_REG;
        src2  = ROLE_RM;
        upper = vec_enc ? UP_ZALL : UP_ZLANE;
      end else begin
        form  = FORM_STORE;
        dst   = ROLE_RM;
        src2  = ROLE_REG;
        upper = UP_NA;
      end
    end
  end
endmodule

// File: rtl/ssmov_guard.sv
module ssmov_guard
  import ssmov_pkg::*;
#(
  parameter int XSPEC_W = 4,
  parameter int KIDX_W  = 3
) (
  input  enc_e                recognised_enc,
  input  logic                recognised,
  input  logic                is_store,
  input  logic [XSPEC_W-1:0]  xspec,
  input  logic                len_bit,
  input  logic [KIDX_W-1:0]   kidx,
  input  logic                zero_bit,
  output mask_e               mask,
  output logic                ud,
  output logic                lwarn
);
  localparam logic [XSPEC_W-1:0] XSPEC_UNUSED = {XSPEC_W{1'b1}};

  logic vec_enc;
  logic msk_enc;
  logic spec_bad;
  logic zero_store;

  assign msk_enc    = (recognised_enc == ENC_VECM);
  assign vec_enc    = (recognised_enc == ENC_VEC2) || msk_enc;
  assign spec_bad   = vec_enc && is_store && (xspec != XSPEC_UNUSED);
  assign zero_store = msk_enc && is_store && zero_bit;
  assign ud         = !recognised || spec_bad || zero_store;
  assign lwarn      = (recognised_enc == ENC_VEC2) && len_bit && !ud;

  always_comb begin
    if (!msk_enc || (kidx == '0)) mask = MASK_OFF;
    else if (zero_bit)            mask = MASK_ZERO;
    else                          mask = MASK_MERGE;
  end
endmodule

// File: rtl/ssmov_ostage.sv
module ssmov_ostage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);
endmodule

// File: rtl/ssmov_decoder.sv
module ssmov_decoder
  import ssmov_pkg::*;
#(
  parameter int XSPEC_W = 4,
  parameter int KIDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_enc,
  input  logic [7:0]         in_opcode,
  input  logic               in_f3,
  input  logic [1:0]         in_mod,
  input  logic [XSPEC_W-1:0] in_xspec,
  input  logic               in_len,
  input  logic [KIDX_W-1:0]  in_kidx,
  input  logic               in_zero,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_form,
  output logic [1:0]         out_dst,
  output logic [1:0]         out_src1,
  output logic [1:0]         out_src2,
  output logic [1:0]         out_mask,
  output logic [2:0]         out_upper,
  output logic               out_ud,
  output logic               out_lenwarn
);
  localparam int DW = $bits(decode_t);

  enc_e    enc;
  logic    recognised, is_store, ud, lwarn;
  form_e   c_form;
  role_e   c_dst, c_src1, c_src2;
  upper_e  c_upper;
  mask_e   g_mask;
  decode_t dec, held;
  logic [DW-1:0] held_bits;

  assign enc = enc_e'(in_enc);

  ssmov_classify u_classify (
    .enc(enc), .opcode(in_opcode), .f3(in_f3), .mod_f(in_mod),
    .recognised(recognised), .is_store(is_store), .form(c_form),
    .dst(c_dst), .src1(c_src1), .src2(c_src2), .upper(c_upper)
  );

  ssmov_guard #(.XSPEC_W(XSPEC_W), .KIDX_W(KIDX_W)) u_guard (
    .recognised_enc(enc), .recognised(recognised), .is_store(is_store),
    .xspec(in_xspec), .len_bit(in_len), .kidx(in_kidx), .zero_bit(in_zero),
    .mask(g_mask), .ud(ud), .lwarn(lwarn)
  );

  // a fault blanks every control field
  always_comb begin
    if (ud) begin
      dec = '{form: FORM_NONE, dst: ROLE_NONE, src1: ROLE_NONE, src2: ROLE_NONE,
              mask: MASK_OFF, upper: UP_NA, ud: 1'b1, lwarn: 1'b0};
    end else begin
      dec = '{form: c_form, dst: c_dst, src1: c_src1, src2: c_src2,
              mask: g_mask, upper: c_upper, ud: 1'b0, lwarn: lwarn};
    end
  end

  ssmov_ostage #(.W(DW)) u_ostage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(dec),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(held_bits)
  );

  assign held        = decode_t'(held_bits);
  assign out_form    = held.form;
  assign out_dst     = held.dst;
  assign out_src1    = held.src1;
  assign out_src2    = held.src2;
  assign out_mask    = held.mask;
  assign out_upper   = held.upper;
  assign out_ud      = held.ud;
  assign out_lenwarn = held.lwarn;

  a_r1_prefix_needed: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_f3 |=> out_valid && out_ud);
  a_r7_spec_fault: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_f3 && (in_enc == 2'd1 || in_enc == 2'd2) &&
    in_opcode == OPC_STORESIDE && in_mod != MOD_REGFORM &&
    in_xspec != {XSPEC_W{1'b1}} |=> out_ud);
  a_r2_fault_form: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ud == (out_form == 2'd3)));
  a_r9_store_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_form == 2'd2 |-> out_mask != 2'd2);
  a_r11_warn_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_lenwarn |-> !out_ud);
endmodule

// File: tb/ssmov_decoder_bench.sv
module ssmov_decoder_bench;
  typedef struct packed {
    logic [1:0]  enc;
    logic [7:0]  opc;
    logic        f3;
    logic [1:0]  md;
    logic [3:0]  xs;
    logic        ln;
    logic [2:0]  k;
    logic        z;
    logic [14:0] exp;
  } vec_t;

  function automatic logic [14:0] ex(int f, int d, int a, int b, int m, int u, int ud, int lw);
    return {f[1:0], d[1:0], a[1:0], b[1:0], m[1:0], u[2:0], ud[0], lw[0]};
  endfunction

  localparam logic [14:0] FLT = ex(3, 0, 0, 0, 0, 4, 1, 0);
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h10, 1'b1, 2'd3, 4'h0, 1'b0, 3'd0, 1'b0, ex(0, 1, 1, 2, 0, 0, 0, 0)}, // R5 R10
    '{2'd0, 8'h11, 1'b1, 2'd3, 4'h0, 1'b0, 3'd0, 1'b0, ex(0, 2, 2, 1, 0, 0, 0, 0)}, // R5
    '{2'd0, 8'h10, 1'b1, 2'd0, 4'h0, 1'b0, 3'd0, 1'b0, ex(1, 1, 0, 2, 0, 1, 0, 0)}, // R3 R10
    '{2'd0, 8'h11, 1'b1, 2'd1, 4'h0, 1'b0, 3'd0, 1'b0, ex(2, 2, 0, 1, 0, 4, 0, 0)}, // R4 R7
    '{2'd1, 8'h10, 1'b1, 2'd3, 4'h5, 1'b0, 3'd0, 1'b0, ex(0, 1, 3, 2, 0, 2, 0, 0)}, // R6
    '{2'd1, 8'h11, 1'b1, 2'd3, 4'h5, 1'b0, 3'd0, 1'b0, ex(0, 2, 3, 1, 0, 2, 0, 0)}, // R6
    '{2'd1, 8'h10, 1'b1, 2'd2, 4'h9, 1'b0, 3'd0, 1'b0, ex(1, 1, 0, 2, 0, 3, 0, 0)}, // R10
    '{2'd1, 8'h11, 1'b1, 2'd0, 4'hF, 1'b0, 3'd0, 1'b0, ex(2, 2, 0, 1, 0, 4, 0, 0)}, // R4 R2
    '{2'd1, 8'h11, 1'b1, 2'd0, 4'hE, 1'b0, 3'd0, 1'b0, FLT},                        // R7
    '{2'd1, 8'h10, 1'b1, 2'd3, 4'h2, 1'b1, 3'd0, 1'b0, ex(0, 1, 3, 2, 0, 2, 0, 1)}, // R11
    '{2'd1, 8'h11, 1'b1, 2'd2, 4'h7, 1'b1, 3'd0, 1'b0, FLT},                        // R11 R7
    '{2'd2, 8'h10, 1'b1, 2'd3, 4'h1, 1'b0, 3'd3, 1'b0, ex(0, 1, 3, 2, 1, 2, 0, 0)}, // R8
    '{2'd2, 8'h11, 1'b1, 2'd3, 4'h1, 1'b0, 3'd5, 1'b1, ex(0, 2, 3, 1, 2, 2, 0, 0)}, // R8
    '{2'd2, 8'h10, 1'b1, 2'd1, 4'hF, 1'b0, 3'd0, 1'b1, ex(1, 1, 0, 2, 0, 3, 0, 0)}, // R8
    '{2'd2, 8'h11, 1'b1, 2'd0, 4'hF, 1'b0, 3'd2, 1'b0, ex(2, 2, 0, 1, 1, 4, 0, 0)}, // R9
    '{2'd2, 8'h11, 1'b1, 2'd0, 4'hF, 1'b0, 3'd2, 1'b1, FLT},                        // R9
    '{2'd2, 8'h10, 1'b1, 2'd3, 4'h3, 1'b1, 3'd1, 1'b0, ex(0, 1, 3, 2, 1, 2, 0, 0)}, // R11
    '{2'd0, 8'h10, 1'b0, 2'd3, 4'h0, 1'b0, 3'd0, 1'b0, FLT},                        // R1
    '{2'd1, 8'h12, 1'b1, 2'd3, 4'h0, 1'b0, 3'd0, 1'b0, FLT},                        // R1
    '{2'd3, 8'h10, 1'b1, 2'd3, 4'h0, 1'b0, 3'd0, 1'b0, FLT}                         // R1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [1:0] in_enc = '0, in_mod = '0;
  logic [7:0] in_opcode = '0;
  logic in_f3 = 1'b0, in_len = 1'b0, in_zero = 1'b0;
  logic [3:0] in_xspec = '0;
  logic [2:0] in_kidx = '0;
  logic [1:0] out_form, out_dst, out_src1, out_src2, out_mask;
  logic [2:0] out_upper;
  logic out_ud, out_lenwarn;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ssmov_decoder u_ssmov_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_enc(in_enc), .in_opcode(in_opcode), .in_f3(in_f3), .in_mod(in_mod),
    .in_xspec(in_xspec), .in_len(in_len), .in_kidx(in_kidx), .in_zero(in_zero),
    .out_valid(out_valid), .out_ready(out_ready), .out_form(out_form),
    .out_dst(out_dst), .out_src1(out_src1), .out_src2(out_src2),
    .out_mask(out_mask), .out_upper(out_upper), .out_ud(out_ud),
    .out_lenwarn(out_lenwarn)
  );

  function automatic logic [14:0] actual();
    return {out_form, out_dst, out_src1, out_src2, out_mask, out_upper, out_ud, out_lenwarn};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive(vec_t v);
    in_enc = v.enc; in_opcode = v.opc; in_f3 = v.f3; in_mod = v.md;
    in_xspec = v.xs; in_len = v.ln; in_kidx = v.k; in_zero = v.z;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset valid", {31'd0, out_valid}, 32'd0);
    check("R13 reset ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check("vector valid R12", {31'd0, out_valid}, 32'd1);
      check($sformatf("vector %0d (tags beside table)", i), {17'd0, actual()}, {17'd0, VECS[i].exp});
    end
    @(negedge clk);
    check("R12 drains", {31'd0, out_valid}, 32'd0);
    // back-pressure: R12
    out_ready = 1'b0;
    drive(VECS[0]);
    @(negedge clk);
    check("R12 held first", {17'd0, actual()}, {17'd0, VECS[0].exp});
    check("R12 ready low", {31'd0, in_ready}, 32'd0);
    drive(VECS[5]);
    repeat (2) @(negedge clk);
    check("R12 still first", {17'd0, actual()}, {17'd0, VECS[0].exp});
    check("R12 valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 second out", {17'd0, actual()}, {17'd0, VECS[5].exp});
    @(negedge clk);
    check("R12 empty", {31'd0, out_valid}, 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule